// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block takes one raw operand of up to 128 bits together with a format code and turns it into a single internal form that later arithmetic can work on. The format code selects a signed 32-bit integer, a signed 64-bit integer, or an IEEE single, double or quad value. The internal form has a sign, a signed unbiased exponent, a 116-bit mantissa whose leading one sits at bit 112, and a class code. The block also raises an invalid-operation flag, and a format-error flag when the format code is not supported.

All five formats go through one shared decode path. Float fields are lined up to the same mantissa position, so the fraction always fills the bits just below bit 112. A single leading-zero normalizer serves both denormal floats and integer magnitudes. A signalling NaN is quieted on the way in. The class code still records that it was signalling.

The operand enters on a valid/ready stream and the result leaves on another, through one register stage. A result is presented in the cycle after its operand is accepted. While the result is not taken, it stays unchanged on the output and the input is back-pressured: `in_ready` is high only when the output register is empty or is being emptied in the same cycle.

Top module: `fp_unpack`

## Requirements
- R1: The output sign is bit 127 of `in_opnd` for every format. Bits that the selected format does not use have no effect on the result.
- R2: The format codes are 0 for signed 32-bit integer (bits 127:96), 1 for signed 64-bit integer (bits 127:64), 2 for single (bits 127:96), 3 for double (bits 127:64) and 4 for quad (bits 127:0). Codes 5 to 7 set `out_fmt_err` and keep `out_invalid` low. A supported code clears `out_fmt_err`.
- R3: The class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signalling NaN. A float whose exponent field and fraction are both zero, and an integer equal to zero, give class 0.
- R4: A normal float gives class 1 and an exponent equal to the field value minus the bias (127, 1023 or 16383). The mantissa has a one at bit 112 and the fraction (23, 52 or 112 bits) in the bits just below it, with zeros elsewhere.
- R5: A float with a zero exponent field and a nonzero fraction gives class 1. Its fraction is shifted left until the top set bit reaches bit 112, and its exponent is 1 minus the bias minus the shift distance.
- R6: An all-ones exponent field with a zero fraction gives class 2.
- R7: An all-ones exponent field with a nonzero fraction whose top bit is set gives class 3, with the aligned fraction passed through unchanged and no implied one.
- R8: An all-ones exponent field with a nonzero fraction whose top bit is clear gives class 4. The mantissa is the aligned fraction with bit 111 set, and `out_invalid` goes high. `out_invalid` is high for no other result.
- R9: A nonzero integer gives class 1. Its magnitude is shifted so that its top set bit lands on bit 112, and the exponent is the index of that bit within the magnitude.
- R10: The 64-bit integer 0x8000000000000000 gives sign 1, exponent 63 and a mantissa holding only bit 112.
- R11: A result appears on the output in the cycle after its operand is accepted. It is held stable while `out_valid` is high and `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_fmt | input | 3 | Format code |
| in_opnd | input | 128 | Raw operand, first word in bits 127:96 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sign | output | 1 | Sign of the operand |
| out_exp | output | 17 | Signed unbiased exponent |
| out_mant | output | 116 | Mantissa, leading one at bit 112 |
| out_cls | output | 3 | Class code |
| out_invalid | output | 1 | Invalid operation (signalling NaN input) |
| out_fmt_err | output | 1 | Unsupported format code |

## Verification
The bench builds the block with its package defaults: a 116-bit mantissa, a 17-bit exponent and a 113-bit normalizer. These widths let the smallest quad denormal (exponent -16494) and the most negative 64-bit integer be checked exactly. Operands are sent both with a consumer that is always ready and with one that stalls on a repeating pattern. The stalled phase exercises held results and back-pressure on the input side. Single-word formats carry junk in their unused low words, which checks that those bits are ignored.

// File: rtl/fp_unpack_pkg.sv
package fp_unpack_pkg;
  localparam int OPND_W  = 128;
  localparam int LEAD_BIT = 112;
  localparam int MANT_W  = LEAD_BIT + 4;
  localparam int EXP_W   = 17;
  localparam int NORM_W  = LEAD_BIT + 1;
  localparam int LZ_W    = $clog2(NORM_W);
  localparam int INT_W   = 64;
  localparam int N_FLT   = 3;

  typedef enum logic [2:0] {
    FMT_I32 = 3'd0, FMT_I64 = 3'd1, FMT_SGL = 3'd2, FMT_DBL = 3'd3, FMT_QUAD = 3'd4
  } fmt_e;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0, CLS_NUM = 3'd1, CLS_INF = 3'd2, CLS_QNAN = 3'd3, CLS_SNAN = 3'd4
  } cls_e;

  typedef struct packed {
    logic                    sign;
    logic signed [EXP_W-1:0] exp;
    logic [MANT_W-1:0]       mant;
    cls_e                    cls;
    logic                    invalid;
    logic                    fmt_err;
  } unpk_t;
endpackage

// File: rtl/fp_field_split.sv
module fp_field_split
  import fp_unpack_pkg::*;
(
  input  logic [OPND_W-1:0]         opnd,
  output logic [N_FLT-1:0]          exp_zero,
  output logic [N_FLT-1:0]          exp_ones,
  output logic [N_FLT-1:0]          frac_nz,
  output logic [N_FLT-1:0][LEAD_BIT-1:0] frac_al,
  output logic signed [N_FLT-1:0][EXP_W-1:0] unb_exp,
  output logic signed [N_FLT-1:0][EXP_W-1:0] den_base
);
  // One field extractor per IEEE width: index 0 single, 1 double, 2 quad
  for (genvar g = 0; g < N_FLT; g++) begin : g_fmt
    localparam int EW   = (g == 0) ? 8  : (g == 1) ? 11 : 15;
    localparam int FW   = (g == 0) ? 23 : (g == 1) ? 52 : 112;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    logic [EW-1:0] efld;
    logic [FW-1:0] ffld;
    assign efld        = opnd[OPND_W-2 -: EW];
    assign ffld        = opnd[OPND_W-2-EW -: FW];
    assign exp_zero[g] = (efld == '0);
    assign exp_ones[g] = &efld;
    assign frac_nz[g]  = |ffld;
    assign frac_al[g]  = LEAD_BIT'(ffld) << (LEAD_BIT - FW);
    assign unb_exp[g]  = $signed(EXP_W'(efld)) - $signed(EXP_W'(BIAS));
    assign den_base[g] = $signed(EXP_W'(1)) - $signed(EXP_W'(BIAS));
  end
endmodule

// File: rtl/fp_lzc_norm.sv
module fp_lzc_norm
  import fp_unpack_pkg::*;
(
  input  logic [NORM_W-1:0] vec,
  output logic [NORM_W-1:0] shifted,
  output logic [LZ_W-1:0]   lz
);
  always_comb begin
    lz = '0;
    for (int i = 0; i < NORM_W; i++) begin
      if (vec[i]) lz = LZ_W'(NORM_W - 1 - i);
    end
    shifted = vec << lz;
  end
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
  import fp_unpack_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_fmt,
  input  logic [OPND_W-1:0]  in_opnd,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_sign,
  output logic [EXP_W-1:0]   out_exp,
  output logic [MANT_W-1:0]  out_mant,
  output logic [2:0]         out_cls,
  output logic               out_invalid,
  output logic               out_fmt_err
);
  logic [N_FLT-1:0]                    ez, eo, fnz;
  logic [N_FLT-1:0][LEAD_BIT-1:0]      fal;
  logic signed [N_FLT-1:0][EXP_W-1:0]  ue, db;

  fp_field_split u_split (
    .opnd(in_opnd), .exp_zero(ez), .exp_ones(eo), .frac_nz(fnz),
    .frac_al(fal), .unb_exp(ue), .den_base(db)
  );

  logic                    is_int, fmt_ok;
  logic [1:0]              fi;
  logic [INT_W-1:0]        ival, imag;
  logic [NORM_W-1:0]       nvec, nsh;
  logic [LZ_W-1:0]         nlz;
  logic signed [EXP_W-1:0] nbase, nexp;
  unpk_t                   res_d, res_q;

  assign is_int = (in_fmt == FMT_I32) || (in_fmt == FMT_I64);
  assign fmt_ok = (in_fmt <= FMT_QUAD);
  assign fi     = (in_fmt == FMT_SGL) ? 2'd0 : (in_fmt == FMT_DBL) ? 2'd1 : 2'd2;

  // Integer magnitude; the 64-bit negation wraps the minimum onto 2^63
  assign ival = (in_fmt == FMT_I32) ? {{32{in_opnd[OPND_W-1]}}, in_opnd[OPND_W-1 -: 32]}
                                    : in_opnd[OPND_W-1 -: INT_W];
  assign imag = ival[INT_W-1] ? (~ival + INT_W'(1)) : ival;

  // Shared normalizer: integer magnitude or denormal fraction
  assign nvec  = is_int ? {imag, (NORM_W-INT_W)'(0)} : {1'b0, fal[fi]};
  assign nbase = is_int ? $signed(EXP_W'(INT_W - 1)) : db[fi];

  fp_lzc_norm u_norm (.vec(nvec), .shifted(nsh), .lz(nlz));

  assign nexp = nbase - $signed(EXP_W'(nlz));

  always_comb begin
    res_d         = '0;
    res_d.sign    = in_opnd[OPND_W-1];
    res_d.cls     = CLS_ZERO;
    if (!fmt_ok) begin
      res_d.fmt_err = 1'b1;
    end else if (is_int) begin
      if (imag != '0) begin
        res_d.cls  = CLS_NUM;
        res_d.exp  = nexp;
        res_d.mant = MANT_W'(nsh);
      end
    end else if (ez[fi]) begin
      if (fnz[fi]) begin
        res_d.cls  = CLS_NUM;
        res_d.exp  = nexp;
        res_d.mant = MANT_W'(nsh);
      end
    end else if (eo[fi]) begin
      if (!fnz[fi]) begin
        res_d.cls = CLS_INF;
      end else begin
        res_d.mant = MANT_W'(fal[fi]);
        if (fal[fi][LEAD_BIT-1]) begin
          res_d.cls = CLS_QNAN;
        end else begin
          res_d.cls              = CLS_SNAN;
          res_d.mant[LEAD_BIT-1] = 1'b1;
          res_d.invalid          = 1'b1;
        end
      end
    end else begin
      res_d.cls  = CLS_NUM;
      res_d.exp  = ue[fi];
      res_d.mant = MANT_W'({1'b1, fal[fi]});
    end
  end

  // One-deep output register with valid/ready
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      res_q     <= res_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_sign    = res_q.sign;
  assign out_exp     = res_q.exp;
  assign out_mant    = res_q.mant;
  assign out_cls     = res_q.cls;
  assign out_invalid = res_q.invalid;
  assign out_fmt_err = res_q.fmt_err;

  AST_NUM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cls == CLS_NUM && !out_fmt_err) |->
      (out_mant[LEAD_BIT] && out_mant[MANT_W-1:LEAD_BIT+1] == '0)); // R4
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_cls == CLS_QNAN || out_cls == CLS_SNAN)) |->
      (out_mant[LEAD_BIT-1] && !out_mant[LEAD_BIT])); // R8
  AST_INV_ONLY_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_cls == CLS_SNAN && !out_fmt_err)); // R8
  AST_BADFMT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt_err) |-> !out_invalid); // R2
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_mant) && $stable(out_exp) && $stable(out_cls))); // R11
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R11
endmodule

// File: tb/fp_unpack_bench.sv
module fp_unpack_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_fmt = '0;
  logic [127:0] in_opnd = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_sign;
  logic [16:0]  out_exp;
  logic [115:0] out_mant;
  logic [2:0]   out_cls;
  logic         out_invalid;
  logic         out_fmt_err;

  fp_unpack u_fp_unpack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_opnd(in_opnd), .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant), .out_cls(out_cls),
    .out_invalid(out_invalid), .out_fmt_err(out_fmt_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic         sign;
    int           exp;
    logic [115:0] mant;
    int           cls;
    logic         inv;
    logic         err;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, sent = 0, got = 0, holds = 0;
  logic bp_en = 1'b0;
  int cyc = 0;

  // Reference model from the requirements
  function automatic exp_t model(input logic [2:0] f, input logic [127:0] d, input string tag);
    exp_t e;
    logic [63:0] v, m;
    int ew, fw, bias, ef, msb;
    logic [115:0] fr;
    e.sign = d[127]; e.exp = 0; e.mant = '0; e.cls = 0; e.inv = 0; e.err = 0; e.tag = tag;
    if (f > 3'd4) begin e.err = 1; return e; end
    if (f <= 3'd1) begin
      v = (f == 3'd0) ? {{32{d[127]}}, d[127:96]} : d[127:64];
      m = v[63] ? (64'd0 - v) : v;
      if (m == 0) return e;
      msb = 0;
      for (int i = 0; i < 64; i++) if (m[i]) msb = i;
      e.cls = 1; e.exp = msb;
      e.mant = {52'd0, m} << (112 - msb);
      return e;
    end
    ew = (f == 3'd2) ? 8 : (f == 3'd3) ? 11 : 15;
    fw = (f == 3'd2) ? 23 : (f == 3'd3) ? 52 : 112;
    bias = (1 << (ew - 1)) - 1;
    ef = 0;
    for (int i = 0; i < ew; i++) if (d[126 - i]) ef += (1 << (ew - 1 - i));
    fr = '0;
    for (int i = 0; i < fw; i++) fr[111 - i] = d[126 - ew - i];
    if (ef == 0) begin
      if (fr == 0) return e;
      msb = 0;
      for (int i = 0; i < 116; i++) if (fr[i]) msb = i;
      e.cls = 1; e.exp = 1 - bias - (112 - msb); e.mant = fr << (112 - msb);
    end else if (ef == (1 << ew) - 1) begin
      if (fr == 0) e.cls = 2;
      else if (fr[111]) begin e.cls = 3; e.mant = fr; end
      else begin e.cls = 4; e.mant = fr; e.mant[111] = 1'b1; e.inv = 1; end
    end else begin
      e.cls = 1; e.exp = ef - bias; e.mant = fr; e.mant[112] = 1'b1;
    end
    return e;
  endfunction

  task automatic send(input logic [2:0] f, input logic [127:0] d, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_fmt = f; in_opnd = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    q.push_back(model(f, d, tag));
    sent++;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Consumer ready pattern, changed just after the edge
  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // Monitor / scoreboard
  logic         stall_prev = 1'b0;
  logic [115:0] hold_mant;
  logic [16:0]  hold_exp;
  logic [2:0]   hold_cls;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        checks++; holds++;
        if (!out_valid || out_mant !== hold_mant || out_exp !== hold_exp || out_cls !== hold_cls) begin
          errors++;
          $display("FAIL R11 held result changed: valid=%0b cls=%0d exp=%0h expected valid=1 cls=%0d exp=%0h",
                   out_valid, out_cls, out_exp, hold_cls, hold_exp);
        end
      end
      stall_prev = out_valid && !out_ready;
      hold_mant = out_mant; hold_exp = out_exp; hold_cls = out_cls;
      if (out_valid && out_ready) begin
        exp_t e;
        logic bad;
        got++;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected result cls=%0d expected none", out_cls);
        end else begin
          e = q.pop_front();
          bad = (out_fmt_err !== e.err) || (out_invalid !== e.inv);
          if (!e.err) begin
            bad = bad || (out_sign !== e.sign) || (int'(out_cls) != e.cls);
            if (e.cls == 1) bad = bad || ($signed(out_exp) != e.exp);
            if (e.cls == 1 || e.cls >= 3) bad = bad || (out_mant !== e.mant);
          end
          if (bad) begin
            errors++;
            $display("FAIL %s: got s=%0b cls=%0d exp=%0d mant=%h inv=%0b err=%0b expected s=%0b cls=%0d exp=%0d mant=%h inv=%0b err=%0b",
                     e.tag, out_sign, out_cls, $signed(out_exp), out_mant, out_invalid, out_fmt_err,
                     e.sign, e.cls, e.exp, e.mant, e.inv, e.err);
          end
        end
      end
    end
  end

  task automatic run_vectors(input string ph);
    send(3'd0, {32'h0000_0000, 96'h5A5A}, {ph, " R3 int32 zero"});
    send(3'd0, {32'h0000_0001, 96'h0}, {ph, " R9 int32 one"});
    send(3'd0, {32'hFFFF_FFFF, 96'hFFFF}, {ph, " R1 R9 int32 minus one"});
    send(3'd0, {32'h8000_0000, 96'h0}, {ph, " R9 int32 min"});
    send(3'd0, {32'd12345, 96'h1234}, {ph, " R9 int32 12345"});
    send(3'd1, {64'h8000_0000_0000_0000, 64'h0}, {ph, " R10 int64 min"});
    send(3'd1, {64'hFFFF_FFFF_FFFF_FFFD, 64'h0}, {ph, " R9 int64 minus three"});
    send(3'd1, {64'h0000_0001_0000_0001, 64'hABCD}, {ph, " R9 int64 wide"});
    send(3'd1, {64'h0, 64'hFFFF}, {ph, " R3 int64 zero"});
    send(3'd2, {32'h3F80_0000, 96'hDEAD_BEEF_0000_1111}, {ph, " R4 R1 single 1.0"});
    send(3'd2, {32'hC020_0000, 96'h0}, {ph, " R4 single -2.5"});
    send(3'd2, {32'h0000_0001, 96'h0}, {ph, " R5 single min denormal"});
    send(3'd2, {32'h0040_0000, 96'h0}, {ph, " R5 single top denormal"});
    send(3'd2, {32'h8000_0000, 96'h77}, {ph, " R3 single negative zero"});
    send(3'd2, {32'h7F80_0000, 96'h0}, {ph, " R6 single inf"});
    send(3'd2, {32'h7FC0_0001, 96'h0}, {ph, " R7 single qnan"});
    send(3'd2, {32'hFF80_0001, 96'h0}, {ph, " R8 single snan"});
    send(3'd3, {64'h3FF0_0000_0000_0001, 64'hFFFF}, {ph, " R4 double"});
    send(3'd3, {64'h0000_0000_0000_0001, 64'h0}, {ph, " R5 double min denormal"});
    send(3'd3, {64'hFFF0_0000_0000_0000, 64'h0}, {ph, " R6 double -inf"});
    send(3'd3, {64'h7FF0_0000_0000_0001, 64'h0}, {ph, " R8 double snan"});
    send(3'd4, {32'h3FFF_0000, 96'h1}, {ph, " R4 quad 1.0+ulp"});
    send(3'd4, 128'h1, {ph, " R5 quad min denormal"});
    send(3'd4, {32'h7FFF_8000, 96'h5}, {ph, " R7 quad qnan"});
    send(3'd4, {32'h7FFF_0000, 96'h1}, {ph, " R8 quad snan"});
    send(3'd5, {32'h7F80_0001, 96'h0}, {ph, " R2 bad format 5"});
    send(3'd7, 128'h0, {ph, " R2 bad format 7"});
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 reset state: out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    run_vectors("flow");
    bp_en = 1'b1;
    run_vectors("stall");
    bp_en = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    checks++;
    if (got != sent || q.size() != 0) begin
      errors++;
      $display("FAIL R11 result count: got %0d expected %0d", got, sent);
    end
    checks++;
    if (holds == 0) begin
      errors++;
      $display("FAIL R11 no stalled result observed: got 0 expected >0");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule